// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display. It also reports the pixel position inside the visible area and gives a one-cycle pulse at the start of each frame, which an interrupt block can count. Pixel counting starts at the leading edge of sync. Each axis is set by four absolute counts: sync end, active start, active end and total. Software derives these as sync length; sync plus back porch; that sum plus active size; and the sum of all four parts.

A small 32-bit register bank takes the configuration. Timing, polarity and output-mode writes go into shadow copies. They reach the live timing only when software writes a commit. The block holds the commit until the next frame boundary, so a frame is never built from a mix of old and new settings. A standby bit acts at once: it forces every strobe to its inactive level and stops the frame pulse. The counters keep running while standby is set.

Top module: `raster_timing_gen`

## Requirements
- R1: During reset every strobe is at its inactive level (the default polarity is all active-high), x and y are 0, the frame pulse is low, the commit flag reads 0, and the horizontal timing register reads its parameter default.
- R2: Each timing register holds two 13-bit values, one in bits [12:0] and one in bits [28:16]. A read returns the written value with all other bits cleared. Map: 0x020 holds hsync end [12:0] and line total [28:16]; 0x024 holds active end [12:0] and active start [28:16]; 0x028 and 0x02C hold the same fields in lines for the vertical axis. Reads return data one cycle after the read strobe.
- R3: Within a line, the horizontal count runs from 0 to total-1. hsync is active for counts below the sync end.
- R4: The line count advances once at the end of each line and wraps after total lines. vsync is active for line counts below the vertical sync end. A frame lasts exactly htotal*vtotal cycles.
- R5: data-enable is active only when the horizontal count is in [active start, active end) and the line count is in its own vertical window. x_o is the count minus the active start inside the horizontal window and 0 outside it. y_o follows the same rule on the vertical axis.
- R6: Bits [7:4] of the control register at 0x010 set polarity: bit 4 for hsync, bit 5 for vsync, bit 6 for data-enable, bit 7 for the pixel clock. A set bit makes the strobe active-high. pclk_pol_o shows the live bit 7.
- R7: Timing, polarity and output-mode writes without a commit leave the live timing and the outputs unchanged.
- R8: Writing 1 to bit 0 at 0x000 sets the commit flag, which reads back in bit 0. The commit takes effect at the next frame wrap, and the flag then reads 0. A write of 0 to that bit has no effect.
- R9: Bit 22 at 0x008 (standby) takes effect on the next output cycle. While it is set, every strobe is inactive, x and y are 0 and no frame pulse is produced. When it is cleared, output resumes.
- R10: frame_o pulses for one cycle when the output shows horizontal count 0 and line count 0, and standby is clear.
- R11: Bits [3:0] at 0x010 select the output mode. Code 0 is 8 bits per channel and code 15 is 10 bits per channel (deep_color_o = 1). The mode changes only on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| hsync_o | output | 1 | Horizontal sync with polarity applied |
| vsync_o | output | 1 | Vertical sync with polarity applied |
| de_o | output | 1 | Data-enable with polarity applied |
| pclk_pol_o | output | 1 | Live pixel-clock polarity bit |
| out_mode_o | output | 4 | Live output-mode code |
| deep_color_o | output | 1 | 1 when the live mode is 10 bits per channel |
| x_o | output | 13 | Horizontal offset inside the active area |
| y_o | output | 13 | Vertical offset inside the active area |
| frame_o | output | 1 | One-cycle frame-start pulse |

## Verification
The timing is checked over whole frames. The reset defaults come first, then a fixed mixed-polarity setup, then random porch, sync and active sizes with random polarity nibbles. Every output cycle is compared against a bench model of the counters. A wrong window bound, an off-by-one total or a swapped polarity bit each shows up in a different strobe. Uncommitted writes of oversized values confirm that the shadows stay separate from the live timing. A commit placed mid-frame shows that the change waits for the next frame boundary. A standby interval with the counters still running separates the strobe gating from the counting.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Field width fixed by the register format (two 13-bit fields per word)
  localparam int FW = 13;

  localparam logic [11:0] OFS_COMMIT = 12'h000;
  localparam logic [11:0] OFS_SYS    = 12'h008;
  localparam logic [11:0] OFS_CTRL   = 12'h010;
  localparam logic [11:0] OFS_HSYNC  = 12'h020;
  localparam logic [11:0] OFS_HACT   = 12'h024;
  localparam logic [11:0] OFS_VSYNC  = 12'h028;
  localparam logic [11:0] OFS_VACT   = 12'h02C;

  localparam int STANDBY_BIT = 22;
  localparam logic [3:0] MODE_DEEP = 4'd15;

  typedef struct packed {
    logic [FW-1:0] h_sync_end;
    logic [FW-1:0] h_total;
    logic [FW-1:0] h_act_st;
    logic [FW-1:0] h_act_end;
    logic [FW-1:0] v_sync_end;
    logic [FW-1:0] v_total;
    logic [FW-1:0] v_act_st;
    logic [FW-1:0] v_act_end;
    logic [3:0]    pol;   // [3] pclk, [2] de, [1] vsync, [0] hsync
    logic [3:0]    mode;
  } rtg_cfg_t;
endpackage

// File: rtl/rtg_cfg_bank.sv
module rtg_cfg_bank
  import rtg_pkg::*;
#(
  parameter int       ADDR_W  = 8,
  parameter rtg_cfg_t RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic              frame_wrap,
  output rtg_cfg_t          live_cfg,
  output logic              standby,
  output logic              pending
);
  rtg_cfg_t    shadow;
  logic        commit_wr;
  logic [31:0] rd_mux;
  logic        unused_wbits;

  assign commit_wr    = wr_en && (addr == ADDR_W'(OFS_COMMIT)) && wdata[0];
  assign unused_wbits = ^{wdata[31:29], wdata[15:13], wdata[21:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= RST_CFG;
      live_cfg <= RST_CFG;
      standby  <= 1'b0;
      pending  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_SYS))   standby <= wdata[STANDBY_BIT];
        if (addr == ADDR_W'(OFS_CTRL)) begin
          shadow.mode <= wdata[3:0];
          shadow.pol  <= wdata[7:4];
        end
        if (addr == ADDR_W'(OFS_HSYNC)) begin
          shadow.h_sync_end <= wdata[FW-1:0];
          shadow.h_total    <= wdata[16+FW-1:16];
        end
        if (addr == ADDR_W'(OFS_HACT)) begin
          shadow.h_act_end <= wdata[FW-1:0];
          shadow.h_act_st  <= wdata[16+FW-1:16];
        end
        if (addr == ADDR_W'(OFS_VSYNC)) begin
          shadow.v_sync_end <= wdata[FW-1:0];
          shadow.v_total    <= wdata[16+FW-1:16];
        end
        if (addr == ADDR_W'(OFS_VACT)) begin
          shadow.v_act_end <= wdata[FW-1:0];
          shadow.v_act_st  <= wdata[16+FW-1:16];
        end
      end
      // Commit lands only on a frame wrap; a commit written on the wrap edge counts
      if (frame_wrap) begin
        if (pending || commit_wr) live_cfg <= shadow;
        pending <= 1'b0;
      end else if (commit_wr) begin
        pending <= 1'b1;
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_COMMIT)) rd_mux[0] = pending;
    if (addr == ADDR_W'(OFS_SYS))    rd_mux[STANDBY_BIT] = standby;
    if (addr == ADDR_W'(OFS_CTRL))   rd_mux[7:0] = {shadow.pol, shadow.mode};
    if (addr == ADDR_W'(OFS_HSYNC))  rd_mux = {3'b0, shadow.h_total, 3'b0, shadow.h_sync_end};
    if (addr == ADDR_W'(OFS_HACT))   rd_mux = {3'b0, shadow.h_act_st, 3'b0, shadow.h_act_end};
    if (addr == ADDR_W'(OFS_VSYNC))  rd_mux = {3'b0, shadow.v_total, 3'b0, shadow.v_sync_end};
    if (addr == ADDR_W'(OFS_VACT))   rd_mux = {3'b0, shadow.v_act_st, 3'b0, shadow.v_act_end};
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] total,
  input  logic [W-1:0] sync_end,
  input  logic [W-1:0] act_st,
  input  logic [W-1:0] act_end,
  output logic [W-1:0] cnt,
  output logic         last,
  output logic         in_sync,
  output logic         in_act,
  output logic [W-1:0] pos
);
  // Totals of 0 or 1 collapse to a single-position axis instead of running away
  assign last    = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, total};
  assign in_sync = cnt < sync_end;
  assign in_act  = (cnt >= act_st) && (cnt < act_end);
  assign pos     = in_act ? (cnt - act_st) : '0;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int H_SYNC = 2,
  parameter int H_BP   = 2,
  parameter int H_ACT  = 8,
  parameter int H_FP   = 2,
  parameter int V_SYNC = 1,
  parameter int V_BP   = 1,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter logic [3:0] DEF_POL = 4'b1111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_pol_o,
  output logic [3:0]        out_mode_o,
  output logic              deep_color_o,
  output logic [FW-1:0]     x_o,
  output logic [FW-1:0]     y_o,
  output logic              frame_o
);
  localparam int H_ST  = H_SYNC + H_BP;
  localparam int H_END = H_ST + H_ACT;
  localparam int H_TOT = H_END + H_FP;
  localparam int V_ST  = V_SYNC + V_BP;
  localparam int V_END = V_ST + V_ACT;
  localparam int V_TOT = V_END + V_FP;

  localparam rtg_cfg_t RST_CFG = '{
    h_sync_end: FW'(H_SYNC), h_total: FW'(H_TOT),
    h_act_st:   FW'(H_ST),   h_act_end: FW'(H_END),
    v_sync_end: FW'(V_SYNC), v_total: FW'(V_TOT),
    v_act_st:   FW'(V_ST),   v_act_end: FW'(V_END),
    pol: DEF_POL, mode: 4'd0
  };

  rtg_cfg_t      live_cfg;
  logic          standby_q, pending;
  logic [FW-1:0] hcnt, vcnt, hpos, vpos;
  logic          h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic          frame_wrap, run;

  assign frame_wrap = h_last && v_last;
  assign run        = !standby_q;

  rtg_cfg_bank #(.ADDR_W(ADDR_W), .RST_CFG(RST_CFG)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rd_en(bus_rd), .rdata(bus_rdata), .frame_wrap(frame_wrap),
    .live_cfg(live_cfg), .standby(standby_q), .pending(pending)
  );

  rtg_axis #(.W(FW)) h_axis_i (
    .clk(clk), .rst(rst), .step(1'b1),
    .total(live_cfg.h_total), .sync_end(live_cfg.h_sync_end),
    .act_st(live_cfg.h_act_st), .act_end(live_cfg.h_act_end),
    .cnt(hcnt), .last(h_last), .in_sync(h_sync), .in_act(h_act), .pos(hpos)
  );

  rtg_axis #(.W(FW)) v_axis_i (
    .clk(clk), .rst(rst), .step(h_last),
    .total(live_cfg.v_total), .sync_end(live_cfg.v_sync_end),
    .act_st(live_cfg.v_act_st), .act_end(live_cfg.v_act_end),
    .cnt(vcnt), .last(v_last), .in_sync(v_sync), .in_act(v_act), .pos(vpos)
  );

  // Registered output stage: polarity bit set means active-high
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o      <= ~DEF_POL[0];
      vsync_o      <= ~DEF_POL[1];
      de_o         <= ~DEF_POL[2];
      pclk_pol_o   <= DEF_POL[3];
      out_mode_o   <= 4'd0;
      deep_color_o <= 1'b0;
      x_o          <= '0;
      y_o          <= '0;
      frame_o      <= 1'b0;
    end else begin
      hsync_o      <= live_cfg.pol[0] ? (h_sync && run) : !(h_sync && run);
      vsync_o      <= live_cfg.pol[1] ? (v_sync && run) : !(v_sync && run);
      de_o         <= live_cfg.pol[2] ? (h_act && v_act && run) : !(h_act && v_act && run);
      pclk_pol_o   <= live_cfg.pol[3];
      out_mode_o   <= live_cfg.mode;
      deep_color_o <= (live_cfg.mode == MODE_DEEP);
      x_o          <= run ? hpos : '0;
      y_o          <= run ? vpos : '0;
      frame_o      <= run && (hcnt == '0) && (vcnt == '0);
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          frame_o,
  input logic [FW-1:0] x_o,
  input logic [FW-1:0] y_o,
  input logic          standby_q,
  input logic [FW-1:0] hcnt,
  input logic [FW-1:0] vcnt,
  input logic          h_last,
  input logic          v_last,
  input logic          pending,
  input logic [FW-1:0] live_htotal
);
  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(standby_q) |-> (!frame_o && x_o == '0 && y_o == '0));

  p_commit_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(live_htotal) |-> (hcnt == '0 && vcnt == '0));

  p_pending_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (h_last && v_last) |=> !pending);

  p_frame_origin_r10: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> (x_o == '0 && y_o == '0));

  p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(vcnt) |-> $past(h_last));

  p_h_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (hcnt == '0) || (hcnt < live_htotal));
endmodule

bind raster_timing_gen rtg_checker chk_i (
  .clk(clk), .rst(rst), .frame_o(frame_o), .x_o(x_o), .y_o(y_o),
  .standby_q(standby_q), .hcnt(hcnt), .vcnt(vcnt), .h_last(h_last),
  .v_last(v_last), .pending(pending), .live_htotal(live_cfg.h_total)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hsync_o, vsync_o, de_o, pclk_pol_o, deep_color_o, frame_o;
  logic [3:0]  out_mode_o;
  logic [12:0] x_o, y_o;

  int total_checks = 0, fail_checks = 0;
  bit done = 0;

  // live (c_) and programmed (n_) configuration as the bench sees it
  int c_hs = 2, c_hbp = 2, c_ha = 8, c_hfp = 2, c_vs = 1, c_vbp = 1, c_va = 4, c_vfp = 1;
  int n_hs, n_hbp, n_ha, n_hfp, n_vs, n_vbp, n_va, n_vfp;
  logic [3:0] c_pol = 4'b1111, c_mode = 4'd0, n_pol, n_mode;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pclk_pol_o(pclk_pol_o), .out_mode_o(out_mode_o),
    .deep_color_o(deep_color_o), .x_o(x_o), .y_o(y_o), .frame_o(frame_o)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    total_checks++;
    if (!ok) begin
      fail_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] pack2(int hi, int lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  task automatic program_cfg();
    bus_write(8'h20, pack2(n_hs + n_hbp + n_ha + n_hfp, n_hs));
    bus_write(8'h24, pack2(n_hs + n_hbp, n_hs + n_hbp + n_ha));
    bus_write(8'h28, pack2(n_vs + n_vbp + n_va + n_vfp, n_vs));
    bus_write(8'h2C, pack2(n_vs + n_vbp, n_vs + n_vbp + n_va));
    bus_write(8'h10, {24'b0, n_pol, n_mode});
  endtask

  task automatic commit();
    bus_write(8'h00, 32'h1);
    c_hs = n_hs; c_hbp = n_hbp; c_ha = n_ha; c_hfp = n_hfp;
    c_vs = n_vs; c_vbp = n_vbp; c_va = n_va; c_vfp = n_vfp;
    c_pol = n_pol; c_mode = n_mode;
  endtask

  task automatic wait_frame();
    int guard = 0;
    @(negedge clk);
    while (!frame_o && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  // Compares one full frame, cycle by cycle, against the bench model
  task automatic run_frame(string tag);
    int hst = c_hs + c_hbp, hend = c_hs + c_hbp + c_ha, ht = c_hs + c_hbp + c_ha + c_hfp;
    int vst = c_vs + c_vbp, vend = c_vs + c_vbp + c_va, vt = c_vs + c_vbp + c_va + c_vfp;
    int eh = 0, ev = 0, ed = 0, exy = 0, ef = 0;
    wait_frame();
    check(frame_o == 1'b1, {"R10 frame pulse ", tag}, frame_o, 1);
    for (int k = 0; k < ht * vt; k++) begin
      int h = k % ht, v = k / ht;
      bit ha_ = (h < c_hs), va_ = (v < c_vs);
      bit hw = (h >= hst) && (h < hend), vw = (v >= vst) && (v < vend);
      if (hsync_o !== (c_pol[0] ? ha_ : !ha_)) eh++;
      if (vsync_o !== (c_pol[1] ? va_ : !va_)) ev++;
      if (de_o !== (c_pol[2] ? (hw && vw) : !(hw && vw))) ed++;
      if (x_o !== 13'(hw ? h - hst : 0) || y_o !== 13'(vw ? v - vst : 0)) exy++;
      if (k > 0 && frame_o !== 1'b0) ef++;
      @(negedge clk);
    end
    check(eh == 0, {"R3 hsync pattern ", tag}, eh, 0);
    check(ev == 0, {"R4 vsync pattern ", tag}, ev, 0);
    check(ed == 0, {"R5 de window ", tag}, ed, 0);
    check(exy == 0, {"R5 x/y offsets ", tag}, exy, 0);
    check(ef == 0, {"R10 single pulse ", tag}, ef, 0);
    check(frame_o == 1'b1, {"R4 frame length ", tag}, frame_o, 1);
    check(pclk_pol_o == c_pol[3], {"R6 pclk polarity ", tag}, pclk_pol_o, c_pol[3]);
    check(deep_color_o == (c_mode == 4'd15) && out_mode_o == c_mode,
          {"R11 output mode ", tag}, out_mode_o, c_mode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total_checks++; fail_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R1 strobes inactive in reset",
          {hsync_o, vsync_o, de_o}, 0);
    check(x_o == 0 && y_o == 0 && frame_o == 0, "R1 position and pulse in reset",
          {x_o, y_o, frame_o}, 0);
    rst = 1'b0;
    bus_read(8'h00, rd); check(rd == 0, "R1 commit flag after reset", rd, 0);
    bus_read(8'h20, rd); check(rd == pack2(14, 2), "R1 default hsync/total", rd, pack2(14, 2));
    run_frame("default");

    // R2 field masking; R7 no effect without commit
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read(8'h24, rd); check(rd == 32'h1FFF_1FFF, "R2 field readback", rd, 32'h1FFF_1FFF);
    bus_write(8'h28, 32'h0003_0001);
    bus_write(8'h10, 32'h0000_00F0 | 32'd15);
    run_frame("R7 uncommitted shadow");
    check(deep_color_o == 1'b0, "R7 mode not live before commit", deep_color_o, 0);

    // Directed mixed polarity setup; R8 commit waits for the frame
    n_hs = 3; n_hbp = 1; n_ha = 5; n_hfp = 2; n_vs = 2; n_vbp = 1; n_va = 3; n_vfp = 1;
    n_pol = 4'b0101; n_mode = 4'd0;
    program_cfg();
    wait_frame();
    commit();
    bus_read(8'h00, rd); check(rd[0] == 1'b1, "R8 commit flag pending", rd[0], 1);
    run_frame("R6 mixed polarity");
    bus_read(8'h00, rd); check(rd[0] == 1'b0, "R8 commit flag cleared", rd[0], 0);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, rd); check(rd[0] == 1'b0, "R8 zero write ignored", rd[0], 0);

    // R11 deep mode only after commit
    n_mode = 4'd15; n_pol = 4'b1010;
    bus_write(8'h10, {24'b0, n_pol, n_mode});
    repeat (3) @(negedge clk);
    check(deep_color_o == 1'b0, "R11 deep mode held in shadow", deep_color_o, 0);
    commit();
    run_frame("R11 deep mode");

    // R9 standby
    begin
      int bad = 0;
      bus_write(8'h08, 32'h1 << 22);
      @(negedge clk);
      for (int k = 0; k < 200; k++) begin
        if (hsync_o !== !c_pol[0] || vsync_o !== !c_pol[1] || de_o !== !c_pol[2] ||
            frame_o !== 1'b0 || x_o !== 0 || y_o !== 0) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R9 outputs inactive in standby", bad, 0);
      bus_read(8'h08, rd); check(rd == (32'h1 << 22), "R9 standby readback", rd, 32'h1 << 22);
      bus_write(8'h08, 32'h0);
      run_frame("R9 resume");
    end

    // Random setups
    for (int i = 0; i < 6; i++) begin
      n_hs = 1 + $urandom_range(2, 0); n_hbp = $urandom_range(3, 0);
      n_ha = 1 + $urandom_range(7, 0); n_hfp = $urandom_range(3, 0);
      n_vs = 1 + $urandom_range(1, 0); n_vbp = $urandom_range(2, 0);
      n_va = 1 + $urandom_range(3, 0); n_vfp = $urandom_range(2, 0);
      n_pol = 4'($urandom_range(15, 0));
      n_mode = ($urandom_range(1, 0) == 1) ? 4'd15 : 4'd0;
      program_cfg();
      commit();
      run_frame($sformatf("R3 random %0d", i));
    end

    done = 1;
    $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
    $finish;
  end
endmodule